// File: doc/BRIEF.md
# Reloading Timer with Baud Tick Generator

This block is a 16-bit timer/counter with a 16-bit companion register that acts either as a reload value or as a capture target. It has three modes. In auto-reload mode an overflow or an external trigger loads the count from the companion register. In capture mode the trigger copies the count into the companion register instead. In baud generation mode the block produces serial bit-clock ticks. The count source is either an internal prescaler or the falling edges of an external count pin. The external count pin passes through a two-flop synchronizer.

In baud mode the prescaler speeds up to one step per two clocks. Every high-byte overflow reloads the count. The overflow flag stays untouched. Every sixteenth overflow emits one tick. The transmit and receive tick outputs each choose independently between this block's tick and a tick supplied by a second timer elsewhere on the chip. In baud mode a falling edge on the trigger pin only raises the external flag, so the pin can serve as a spare interrupt source. Software loads the count, the reload value and the control byte through write strobes, and it clears the sticky flags by writing the control byte.

Top module: `reload_baud_timer`

## Requirements
- R1: After reset the count, reload value and control byte read 0, and both tick outputs follow the alternate tick inputs.
- R2: Control bit 4 selects the source of the transmit tick: 1 uses this timer's tick and 0 uses `alt_tx_tick`. Control bit 5 selects the source of the receive tick in the same way. The block is in baud mode whenever bit 4 or bit 5 is 1.
- R3: With the run bit (bit 2) set and internal clocking (bit 1 clear), the count steps once every 2 clocks in baud mode and once every 12 clocks otherwise. The first step comes that many clocks after the write of the control byte.
- R4: In baud mode the own tick pulses once per 16 overflows. With internal clocking the tick period is 32 × (65536 − reload) clocks.
- R5: In baud mode an overflow loads the count from the reload register and does not set the overflow flag (bit 7).
- R6: In baud mode with external-enable (bit 3) set, a falling trigger edge sets the external flag (bit 6) and leaves the count unchanged.
- R7: Outside baud mode an overflow sets the overflow flag. With capture select (bit 0) clear the count reloads. With capture select set the count wraps to 0 and the reload register is kept.
- R8: Outside baud mode with external-enable set, a falling trigger edge sets the external flag. It then either reloads the count (bit 0 = 0) or copies the count into the reload register (bit 0 = 1). With external-enable clear the trigger has no effect.
- R9: With bit 1 set, each falling edge of the external count pin, after two synchronizer flops, advances the count by exactly one. A steady level does not advance it.
- R10: The overflow and external flags stay set until a control-byte write clears them.
- R11: With the run bit clear the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write data |
| rld_we | input | 1 | Reload/capture register write strobe |
| rld_wdata | input | 16 | Reload/capture write data |
| trig_in | input | 1 | External trigger pin, active falling edge |
| ext_cnt_in | input | 1 | External count pin, active falling edge |
| alt_tx_tick | input | 1 | Transmit tick from the other timer |
| alt_rx_tick | input | 1 | Receive tick from the other timer |
| cnt_q | output | 16 | Current count |
| rld_q | output | 16 | Reload/capture register |
| ctrl_q | output | 8 | Control byte with flags in bits 7 and 6 |
| tx_tick | output | 1 | Transmit baud tick |
| rx_tick | output | 1 | Receive baud tick |

## Verification
A register write lands on the rising edge after the strobe is driven. The first count step follows N edges later, with N equal to 2 or 12 depending on the mode, so the bench samples at the negative edge just before and just after edge N to bracket the step. A trigger or count-pin edge crosses two synchronizer flops and acts on the third rising edge, so the bench checks the count and the flags three negative edges after it drives the pin. Tick outputs are combinational from the current overflow. The bench measures their period as the number of negative-edge samples between two successive pulses and compares that number with the value in its stimulus table.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  typedef struct packed {
    logic ovf_f;    // bit 7 sticky overflow flag
    logic ext_f;    // bit 6 sticky external flag
    logic rx_sel;   // bit 5 receive tick from this timer
    logic tx_sel;   // bit 4 transmit tick from this timer
    logic ext_en;   // bit 3 trigger pin enable
    logic run;      // bit 2 run
    logic cnt_sel;  // bit 1 count external pin edges
    logic cap_sel;  // bit 0 capture instead of reload
  } ctrl_t;

  function automatic logic is_baud(input ctrl_t c);
    return c.rx_sel | c.tx_sel;
  endfunction

  // clocks per count step, internal clocking
  function automatic int unsigned step_clocks(input logic baud, input int unsigned slow_div,
                                              input int unsigned fast_div);
    return baud ? fast_div : slow_div;
  endfunction

endpackage

// File: rtl/rt_fall_detect.sv
module rt_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] sh;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= 1'b1;
          else        sh[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[i] <= 1'b1;
          else        sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import reload_timer_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 12,
  parameter int unsigned FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  logic use_ext,
  input  logic ext_fall,
  output logic step
);
  localparam int PW = $clog2(SLOW_DIV);
  logic [PW-1:0] pc, lim;
  logic          int_step;

  assign lim      = PW'(step_clocks(fast, SLOW_DIV, FAST_DIV) - 1);
  assign int_step = (pc >= lim);
  assign step     = run & (use_ext ? ext_fall : int_step);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        pc <= '0;
    else if (!run || use_ext || step)  pc <= '0;
    else                               pc <= pc + 1'b1;

  AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step); // R3
endmodule

// File: rtl/rt_tick_div.sv
module rt_tick_div #(
  parameter int DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ovf,
  output logic tick
);
  logic [DIV_LOG2-1:0] div;

  assign tick = enable & ovf & (&div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               div <= '0;
    else if (!enable)         div <= '0;
    else if (ovf)             div <= div + 1'b1;
endmodule

// File: rtl/rt_core.sv
module rt_core
  import reload_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [7:0]   ctrl_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  input  logic         step,
  input  logic         trig_fall,
  output ctrl_t        ctrl_q,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         ovf_evt,
  output logic         baud
);
  ctrl_t        wr_c, ctrl_d;
  logic [W-1:0] cnt_d, rld_d;
  logic         trig_evt, trig_reload, trig_capture, ovf_flag_set;

  assign wr_c         = ctrl_t'(ctrl_wdata);
  assign baud         = is_baud(ctrl_q);
  assign ovf_evt      = step & (&cnt_q);
  assign trig_evt     = trig_fall & ctrl_q.ext_en;
  assign trig_reload  = trig_evt & ~baud & ~ctrl_q.cap_sel;
  assign trig_capture = trig_evt & ~baud &  ctrl_q.cap_sel;
  assign ovf_flag_set = ovf_evt & ~baud;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)           cnt_d = cnt_wdata;
    else if (ovf_evt)     cnt_d = (baud || !ctrl_q.cap_sel) ? rld_q : '0;
    else if (trig_reload) cnt_d = rld_q;
    else if (step)        cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    rld_d = rld_q;
    if (rld_we)            rld_d = rld_wdata;
    else if (trig_capture) rld_d = cnt_q;
  end

  always_comb begin
    ctrl_d       = ctrl_we ? wr_c : ctrl_q;
    ctrl_d.ovf_f = ctrl_d.ovf_f | ovf_flag_set;
    ctrl_d.ext_f = ctrl_d.ext_f | trig_evt;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ctrl_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      ctrl_q <= ctrl_d;
    end

  AST_BAUD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && ovf_evt && !cnt_we) |=> cnt_q == $past(rld_q)); // R5
  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ctrl_q.ovf_f && !ctrl_we) |=> !ctrl_q.ovf_f); // R5
  AST_BAUD_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && trig_evt && !step && !cnt_we) |=> $stable(cnt_q)); // R6
  AST_EXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> ctrl_q.ext_f); // R8
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_capture && !rld_we) |=> rld_q == $past(cnt_q)); // R8
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !baud && ctrl_q.cap_sel && !cnt_we) |=> (cnt_q == '0) && ctrl_q.ovf_f); // R7
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !cnt_we && !trig_evt) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/reload_baud_timer.sv
module reload_baud_timer
  import reload_timer_pkg::*;
#(
  parameter int W        = 16,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2,
  parameter int TICK_LOG2 = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [7:0]   ctrl_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  input  logic         trig_in,
  input  logic         ext_cnt_in,
  input  logic         alt_tx_tick,
  input  logic         alt_rx_tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic [7:0]   ctrl_q,
  output logic         tx_tick,
  output logic         rx_tick
);
  ctrl_t c;
  logic  trig_fall, cnt_fall, step, ovf_evt, baud, own_tick;

  rt_fall_detect #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .fall(trig_fall));

  rt_fall_detect #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_cnt_in), .fall(cnt_fall));

  rt_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(c.run), .fast(baud),
    .use_ext(c.cnt_sel), .ext_fall(cnt_fall), .step(step));

  rt_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .step(step), .trig_fall(trig_fall),
    .ctrl_q(c), .cnt_q(cnt_q), .rld_q(rld_q),
    .ovf_evt(ovf_evt), .baud(baud));

  rt_tick_div #(.DIV_LOG2(TICK_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .enable(baud), .ovf(ovf_evt), .tick(own_tick));

  assign ctrl_q  = c;
  assign tx_tick = c.tx_sel ? own_tick : alt_tx_tick;
  assign rx_tick = c.rx_sel ? own_tick : alt_rx_tick;
endmodule

// File: tb/reload_baud_timer_test.sv
module reload_baud_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int ALT_TX = 7;
  localparam int ALT_RX = 11;
  localparam int NV = 5;
  localparam logic [7:0]  V_CTRL [NV] = '{8'h34, 8'h14, 8'h24, 8'h34, 8'h04};
  localparam logic [15:0] V_RLD  [NV] = '{16'hFFFF, 16'hFFFE, 16'hFFFC, 16'hFFF8, 16'hFFFF};
  localparam int          V_TXP  [NV] = '{32, 64, ALT_TX, 256, ALT_TX};
  localparam int          V_RXP  [NV] = '{32, ALT_RX, 128, 256, ALT_RX};
  localparam logic        V_OVF  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, cnt_we = 0, rld_we = 0;
  logic [7:0] ctrl_wdata = 0;
  logic [15:0] cnt_wdata = 0, rld_wdata = 0;
  logic trig_in = 1, ext_cnt_in = 1, alt_tx_tick = 0, alt_rx_tick = 0;
  logic [15:0] cnt_q, rld_q;
  logic [7:0] ctrl_q;
  logic tx_tick, rx_tick;
  int total = 0, bad = 0;
  bit done = 0;

  reload_baud_timer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : alt_gen
    int ct = 0, cr = 0;
    forever begin
      @(posedge clk); #1;
      ct = (ct + 1) % ALT_TX; cr = (cr + 1) % ALT_RX;
      alt_tx_tick = (ct == 0); alt_rx_tick = (cr == 0);
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic wr_rld(input logic [15:0] v);
    @(negedge clk); rld_we = 1; rld_wdata = v;
    @(negedge clk); rld_we = 0;
  endtask
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_trig();
    @(negedge clk); trig_in = 0;
    wait_n(3);
  endtask

  task automatic measure(input bit rx, output int per);
    int t = 0;
    while (!(rx ? rx_tick : tx_tick) && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk); per = 1;
    while (!(rx ? rx_tick : tx_tick) && per < 3000) begin @(negedge clk); per++; end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int per;
    wait_n(3);
    // R1 reset state
    check("R1 cnt", cnt_q, 0); check("R1 rld", rld_q, 0); check("R1 ctrl", ctrl_q, 0);
    check("R1 tx follows alt", tx_tick, alt_tx_tick);
    rst_n = 1;
    wait_n(2);
    check("R1 rx follows alt", rx_tick, alt_rx_tick);

    // table: R2 tick source, R4 tick period, R5/R7 overflow flag
    for (int i = 0; i < NV; i++) begin
      wr_ctrl(8'h00); wr_rld(V_RLD[i]); wr_cnt(V_RLD[i]); wr_ctrl(V_CTRL[i]);
      measure(0, per); check("R2/R4 tx period", per, V_TXP[i]);
      measure(1, per); check("R2/R4 rx period", per, V_RXP[i]);
      check(V_OVF[i] ? "R7 ovf flag" : "R5 ovf flag", ctrl_q[7], V_OVF[i]);
    end

    // R3 step rates
    wr_ctrl(8'h00); wr_cnt(16'h0000); wr_ctrl(8'h04);
    wait_n(59); check("R3 slow before step 5", cnt_q, 4);
    wait_n(1);  check("R3 slow step 5", cnt_q, 5);
    wr_ctrl(8'h00); wr_cnt(16'h0000); wr_ctrl(8'h14);
    wait_n(19); check("R3 fast before step 10", cnt_q, 9);
    wait_n(1);  check("R3 fast step 10", cnt_q, 10);

    // R5 baud overflow reloads
    wr_ctrl(8'h00); wr_rld(16'h8000); wr_cnt(16'hFFFF); wr_ctrl(8'h14);
    wait_n(3); check("R5 reload on baud overflow", cnt_q, 16'h8000);
    check("R5 no ovf flag", ctrl_q[7], 0);

    // R7 auto-reload and capture-mode overflow
    wr_ctrl(8'h00); wr_rld(16'h1234); wr_cnt(16'hFFFF); wr_ctrl(8'h04);
    wait_n(15); check("R7 reload", cnt_q, 16'h1234); check("R7 flag", ctrl_q[7], 1);
    wr_ctrl(8'h00); wr_rld(16'h4321); wr_cnt(16'hFFFE); wr_ctrl(8'h05);
    wait_n(30); check("R7 wrap to 0", cnt_q, 0); check("R7 capture flag", ctrl_q[7], 1);
    check("R7 rld kept", rld_q, 16'h4321);
    // R10 sticky then cleared
    wr_ctrl(8'h00); wait_n(20); check("R10 ovf cleared", ctrl_q[7], 0);

    // R11 stopped count holds
    wr_cnt(16'h1234); wait_n(100); check("R11 hold", cnt_q, 16'h1234);

    // R6 baud trigger: flag only
    wr_rld(16'hAAAA); wr_cnt(16'h0055); wr_ctrl(8'h18);
    pulse_trig(); check("R6 ext flag", ctrl_q[6], 1); check("R6 no reload", cnt_q, 16'h0055);
    trig_in = 1; wait_n(4);
    // R8 ignored when external-enable clear
    wr_ctrl(8'h00); pulse_trig();
    check("R8 ignored flag", ctrl_q[6], 0); check("R8 ignored cnt", cnt_q, 16'h0055);
    trig_in = 1; wait_n(4);
    // R8 reload
    wr_ctrl(8'h08); pulse_trig();
    check("R8 reload", cnt_q, 16'hAAAA); check("R8 flag", ctrl_q[6], 1);
    trig_in = 1; wait_n(4);
    // R8 capture
    wr_ctrl(8'h00); wr_cnt(16'h0077); wr_ctrl(8'h09); pulse_trig();
    check("R8 capture", rld_q, 16'h0077);
    trig_in = 1; wait_n(20);
    check("R10 ext sticky", ctrl_q[6], 1);
    wr_ctrl(8'h09); wait_n(2); check("R10 ext cleared", ctrl_q[6], 0);

    // R9 external counting
    wr_ctrl(8'h00); wr_cnt(16'h0000); wr_ctrl(8'h06);
    for (int k = 0; k < 5; k++) begin
      ext_cnt_in = 0; wait_n(3); ext_cnt_in = 1; wait_n(3);
    end
    wait_n(4); check("R9 five edges", cnt_q, 5);
    wait_n(50); check("R9 steady level", cnt_q, 5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule